// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the package-level power state of a multi-core processor. It moves between a running state, two halt flavours (plain and extended), two stop-grant flavours (plain and extended), and one snoop sub-state for each of the four low-power states. Its inputs are a halt request from each core, a stop-clock request from the system, bus snoop start and completion indications, the interrupt lines, a reset, and two enable bits that select the extended flavours.

It drives the encoded current state and the request to put a stop-grant acknowledge cycle on the bus. It keeps a flag for each interrupt source that arrives during stop grant, and hands those flags back as a one-cycle release vector. It also drives a core-clock enable and a level request that asks a separate operating-point sequencer for the reduced frequency and voltage point. Clock gating, cache snoop work and instruction execution are not modelled here. Each one appears only as a handshake bit.

Entry to stop grant from the running state is a two-step handshake. The block first asks for the acknowledge bus cycle. It then counts a fixed number of bus clocks from the response phase of that cycle before it changes state. If the stop-clock request drops before the count ends, the handshake is abandoned.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The state codes are running=0, halt=1, extended halt=2, stop grant=3, extended stop grant=4, and the snoop states of those four are 5, 6, 7 and 8. After a reset outside the stop-grant family, the state is 0, `sgack_req` is 0, `irq_pend` is 0, `core_clk_en` is 1 and `lowpt_req` is 0.
- R2: From state 0, the block enters a halt state only when every bit of `core_halt` is 1 and `stpclk_req` is 0. It enters state 2 if `xhalt_en` is 1 and state 1 otherwise, one clock after the condition is sampled. With any core still running, it stays in state 0.
- R3: In state 1 or 2, a high level on `irq_smi`, `irq_init`, either bit of `irq_lint`, or `irq_bus` returns the block to state 0 on the next clock.
- R4: In state 1 or 2, `stpclk_req` moves the block on the next clock to state 4 if `xsg_en` is 1, and to state 3 otherwise. When `stpclk_req` later drops, the block returns to the exact halt state it left, not to state 0.
- R5: From state 0, `stpclk_req` raises `sgack_req` one clock later. `sgack_req` stays high up to and including the clock on which `sgack_resp` is sampled. The stop-grant state is entered exactly 20 clocks after that sampling edge.
- R6: If `stpclk_req` drops during the acknowledge request or the 20-clock count, `sgack_req` falls, the count is discarded and the state stays 0. A later request starts a new acknowledge cycle and a full new count.
- R7: The flavour of a stop-grant entry from state 0 is chosen by `xsg_en` as sampled when the request first arrives. A value of 1 selects state 4. Later changes of `xsg_en` have no effect on that entry.
- R8: In states 3, 4, 7 and 8, each of the SMI, INIT, local line 0 and local line 1 inputs sets its own pending bit in `irq_pend` (bit0 SMI, bit1 INIT, bit2 `irq_lint[0]`, bit3 `irq_lint[1]`). Repeated events leave that single bit set. On the move to state 0, `irq_release` shows the pending bits, plus any of these inputs high on that same edge, for one clock, and `irq_pend` clears.
- R9: Reset in the stop-grant family puts the block in its base stop-grant state (3 or 4). It clears `irq_pend` and the memory of a halt state to return to, so a later drop of `stpclk_req` leads to state 0.
- R10: `snp_act` in state 1, 2, 3 or 4 moves the block to the matching snoop state (5, 6, 7 or 8) on the next clock. `snp_done` returns it to exactly the state it left. In a stop-grant state, a snoop takes priority over a drop of `stpclk_req`.
- R11: `core_clk_en` is 0 in states 1 to 4 and 1 in states 0 and 5 to 8. `lowpt_req` is 1 in states 2, 4, 6 and 8 and 0 elsewhere.
- R12: Pending bits carried from stop grant back into a halt state act as a wake event. The halt state returns to 0 on the next clock and releases them on `irq_release`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halt | input | NCORE | Per-core halt or monitor-wait request |
| stpclk_req | input | 1 | System stop-clock request, active high |
| sgack_resp | input | 1 | Response phase of the stop-grant acknowledge cycle |
| snp_act | input | 1 | Bus snoop detected |
| snp_done | input | 1 | Bus snoop serviced |
| irq_smi | input | 1 | System management interrupt |
| irq_init | input | 1 | Init request |
| irq_lint | input | 2 | Local interrupt lines |
| irq_bus | input | 1 | Interrupt delivered over the bus |
| xhalt_en | input | 1 | Select extended halt |
| xsg_en | input | 1 | Select extended stop grant |
| pstate | output | 4 | Current state code |
| sgack_req | output | 1 | Request to issue the stop-grant acknowledge cycle |
| irq_pend | output | 4 | Interrupts latched during stop grant |
| irq_release | output | 4 | One-cycle release of latched interrupts |
| core_clk_en | output | 1 | Core clock enable |
| lowpt_req | output | 1 | Request for the reduced operating point |

## Verification
The exit from stop grant and the capture of a new interrupt can happen on the same clock edge. The bench provokes this by dropping `stpclk_req` while one local line is high, after an SMI was already latched. It then expects the new bit and the older bit together in the one-cycle release vector, with `irq_pend` clear. The same kind of collision is also driven between a snoop and a stop-clock drop. There the bench expects the snoop state first, a return to stop grant, and only then the running state.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [3:0] {
        PS_NORMAL    = 4'd0,
        PS_HALT      = 4'd1,
        PS_XHALT     = 4'd2,
        PS_SG        = 4'd3,
        PS_XSG       = 4'd4,
        PS_HALT_SNP  = 4'd5,
        PS_XHALT_SNP = 4'd6,
        PS_SG_SNP    = 4'd7,
        PS_XSG_SNP   = 4'd8
    } pstate_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_REQ   = 2'd1,
        SEQ_COUNT = 2'd2
    } seq_phase_e;

    typedef enum logic [1:0] {
        RET_NONE  = 2'd0,
        RET_HALT  = 2'd1,
        RET_XHALT = 2'd2
    } ret_e;

    localparam int NIRQ = 4;

    // bit0 SMI, bit1 INIT, bit2 local line 0, bit3 local line 1
    typedef struct packed {
        logic lint1;
        logic lint0;
        logic init;
        logic smi;
    } irq_vec_t;

    function automatic logic state_legal(input pstate_e s);
        case (s)
            PS_NORMAL, PS_HALT, PS_XHALT, PS_SG, PS_XSG,
            PS_HALT_SNP, PS_XHALT_SNP, PS_SG_SNP, PS_XSG_SNP: state_legal = 1'b1;
            default: state_legal = 1'b0;
        endcase
    endfunction

    function automatic logic is_snoop(input pstate_e s);
        case (s)
            PS_HALT_SNP, PS_XHALT_SNP, PS_SG_SNP, PS_XSG_SNP: is_snoop = 1'b1;
            default: is_snoop = 1'b0;
        endcase
    endfunction

    function automatic logic is_sg_family(input pstate_e s);
        case (s)
            PS_SG, PS_XSG, PS_SG_SNP, PS_XSG_SNP: is_sg_family = 1'b1;
            default: is_sg_family = 1'b0;
        endcase
    endfunction

    function automatic logic clock_gated(input pstate_e s);
        case (s)
            PS_HALT, PS_XHALT, PS_SG, PS_XSG: clock_gated = 1'b1;
            default: clock_gated = 1'b0;
        endcase
    endfunction

    function automatic logic low_point(input pstate_e s);
        case (s)
            PS_XHALT, PS_XSG, PS_XHALT_SNP, PS_XSG_SNP: low_point = 1'b1;
            default: low_point = 1'b0;
        endcase
    endfunction

    function automatic pstate_e snoop_of(input pstate_e s);
        case (s)
            PS_HALT:  snoop_of = PS_HALT_SNP;
            PS_XHALT: snoop_of = PS_XHALT_SNP;
            PS_SG:    snoop_of = PS_SG_SNP;
            PS_XSG:   snoop_of = PS_XSG_SNP;
            default:  snoop_of = s;
        endcase
    endfunction

    function automatic pstate_e snoop_base(input pstate_e s);
        case (s)
            PS_HALT_SNP:  snoop_base = PS_HALT;
            PS_XHALT_SNP: snoop_base = PS_XHALT;
            PS_SG_SNP:    snoop_base = PS_SG;
            PS_XSG_SNP:   snoop_base = PS_XSG;
            default:      snoop_base = s;
        endcase
    endfunction

    function automatic pstate_e sg_base(input pstate_e s);
        case (s)
            PS_XSG, PS_XSG_SNP: sg_base = PS_XSG;
            default:            sg_base = PS_SG;
        endcase
    endfunction

endpackage

// File: rtl/psc_entry_seq.sv
module psc_entry_seq
    import pwr_state_pkg::*;
#(
    parameter int SG_DELAY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic stpclk,
    input  logic resp,
    input  logic xsg_en,
    output logic ack_req,
    output logic done,
    output logic done_ext
);

    localparam int CNT_W = (SG_DELAY > 1) ? $clog2(SG_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SG_DELAY - 1);

    seq_phase_e       ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ext_q, ext_d;

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        ext_d = ext_q;
        if (!armed || !stpclk) begin
            ph_d  = SEQ_IDLE;
            cnt_d = '0;
        end else begin
            case (ph_q)
                SEQ_IDLE: begin
                    ph_d  = SEQ_REQ;
                    ext_d = xsg_en;
                end
                SEQ_REQ: begin
                    if (resp) begin
                        ph_d  = SEQ_COUNT;
                        cnt_d = '0;
                    end
                end
                SEQ_COUNT: begin
                    if (cnt_q == CNT_LAST) begin
                        ph_d  = SEQ_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: ph_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= SEQ_IDLE;
            cnt_q <= '0;
            ext_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            ext_q <= ext_d;
        end
    end

    assign ack_req  = (ph_q == SEQ_REQ);
    assign done     = armed && stpclk && (ph_q == SEQ_COUNT) && (cnt_q == CNT_LAST);
    assign done_ext = ext_q;

    // R5: the acknowledge request only stands while the package is running
    p_ack_armed_r5: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> armed);

    // R6: a dropped stop-clock request abandons the handshake
    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (ph_q != SEQ_IDLE && !stpclk) |=> (ph_q == SEQ_IDLE && !ack_req));

endmodule

// File: rtl/psc_irq_latch.sv
module psc_irq_latch
    import pwr_state_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic            release_now,
    input  logic [NIRQ-1:0] irq_in,
    output logic [NIRQ-1:0] pend,
    output logic [NIRQ-1:0] rel
);

    logic [NIRQ-1:0] incoming;

    assign incoming = capture ? irq_in : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            rel  <= '0;
        end else if (release_now) begin
            rel  <= pend | incoming;
            pend <= '0;
        end else begin
            rel  <= '0;
            pend <= pend | incoming;
        end
    end

    // R8: outside stop grant and without a release, pending bits hold
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!capture && !release_now) |=> $stable(pend));

    // R8: a release empties the pending set
    p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
        release_now |=> (pend == '0));

endmodule

// File: rtl/psc_state_fsm.sv
module psc_state_fsm
    import pwr_state_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] core_halt,
    input  logic             stpclk,
    input  logic             snp_act,
    input  logic             snp_done,
    input  logic             wake,
    input  logic             seq_done,
    input  logic             seq_ext,
    input  logic             xhalt_en,
    input  logic             xsg_en,
    output pstate_e          state,
    output logic             to_normal
);

    pstate_e st_q, st_d;
    ret_e    ret_q, ret_d;
    logic    all_halted;

    assign all_halted = &core_halt;

    always_comb begin
        st_d  = st_q;
        ret_d = ret_q;
        if (rst) begin
            ret_d = RET_NONE;
            st_d  = is_sg_family(st_q) ? sg_base(st_q) : PS_NORMAL;
        end else begin
            case (st_q)
                PS_NORMAL: begin
                    if (seq_done) begin
                        st_d  = seq_ext ? PS_XSG : PS_SG;
                        ret_d = RET_NONE;
                    end else if (!stpclk && all_halted) begin
                        st_d = xhalt_en ? PS_XHALT : PS_HALT;
                    end
                end
                PS_HALT, PS_XHALT: begin
                    if (wake) begin
                        st_d = PS_NORMAL;
                    end else if (snp_act) begin
                        st_d = snoop_of(st_q);
                    end else if (stpclk) begin
                        st_d  = xsg_en ? PS_XSG : PS_SG;
                        ret_d = (st_q == PS_XHALT) ? RET_XHALT : RET_HALT;
                    end
                end
                PS_SG, PS_XSG: begin
                    if (snp_act) begin
                        st_d = snoop_of(st_q);
                    end else if (!stpclk) begin
                        ret_d = RET_NONE;
                        case (ret_q)
                            RET_HALT:  st_d = PS_HALT;
                            RET_XHALT: st_d = PS_XHALT;
                            default:   st_d = PS_NORMAL;
                        endcase
                    end
                end
                PS_HALT_SNP, PS_XHALT_SNP, PS_SG_SNP, PS_XSG_SNP: begin
                    if (snp_done) begin
                        st_d = snoop_base(st_q);
                    end
                end
                default: begin
                    st_d  = PS_NORMAL;
                    ret_d = RET_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q  <= st_d;
        ret_q <= ret_d;
    end

    assign state     = st_q;
    assign to_normal = (st_d == PS_NORMAL) && (st_q != PS_NORMAL);

    // R1: an unknown code falls back to the running state
    p_legal_recover_r1: assert property (@(posedge clk) disable iff (rst)
        !state_legal(st_q) |=> (st_q == PS_NORMAL));

    // R2: no halt entry while any core is still running
    p_halt_needs_all_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_NORMAL && !all_halted) |=> !(st_q inside {PS_HALT, PS_XHALT}));

    // R5: from running, stop grant is reached only through a finished count
    p_sg_by_count_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_NORMAL && !seq_done) |=> !(st_q inside {PS_SG, PS_XSG}));

    // R10: a finished snoop returns to exactly the state it interrupted
    p_snoop_back_r10: assert property (@(posedge clk) disable iff (rst)
        (is_snoop(st_q) && snp_done) |=> (st_q == snoop_base($past(st_q))));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NCORE    = 2,
    parameter int SG_DELAY = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] core_halt,
    input  logic             stpclk_req,
    input  logic             sgack_resp,
    input  logic             snp_act,
    input  logic             snp_done,
    input  logic             irq_smi,
    input  logic             irq_init,
    input  logic [1:0]       irq_lint,
    input  logic             irq_bus,
    input  logic             xhalt_en,
    input  logic             xsg_en,
    output logic [3:0]       pstate,
    output logic             sgack_req,
    output logic [3:0]       irq_pend,
    output logic [3:0]       irq_release,
    output logic             core_clk_en,
    output logic             lowpt_req
);

    pstate_e         state;
    logic            to_normal;
    logic            seq_done, seq_ext;
    logic            armed;
    logic            wake;
    irq_vec_t        irq_now;
    logic [NIRQ-1:0] pend, rel;

    assign irq_now.smi   = irq_smi;
    assign irq_now.init  = irq_init;
    assign irq_now.lint0 = irq_lint[0];
    assign irq_now.lint1 = irq_lint[1];

    assign armed = (state == PS_NORMAL);
    assign wake  = irq_smi | irq_init | (|irq_lint) | irq_bus | (|pend);

    psc_entry_seq #(.SG_DELAY(SG_DELAY)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .stpclk   (stpclk_req),
        .resp     (sgack_resp),
        .xsg_en   (xsg_en),
        .ack_req  (sgack_req),
        .done     (seq_done),
        .done_ext (seq_ext)
    );

    psc_state_fsm #(.NCORE(NCORE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .core_halt (core_halt),
        .stpclk    (stpclk_req),
        .snp_act   (snp_act),
        .snp_done  (snp_done),
        .wake      (wake),
        .seq_done  (seq_done),
        .seq_ext   (seq_ext),
        .xhalt_en  (xhalt_en),
        .xsg_en    (xsg_en),
        .state     (state),
        .to_normal (to_normal)
    );

    psc_irq_latch u_irq (
        .clk         (clk),
        .rst         (rst),
        .capture     (is_sg_family(state)),
        .release_now (to_normal),
        .irq_in      (irq_now),
        .pend        (pend),
        .rel         (rel)
    );

    assign pstate      = state;
    assign irq_pend    = pend;
    assign irq_release = rel;
    assign core_clk_en = !clock_gated(state);
    assign lowpt_req   = low_point(state);

    // R11: the acknowledge cycle is only requested with the core clock running
    p_ack_clk_r11: assert property (@(posedge clk) disable iff (rst)
        sgack_req |-> core_clk_en);

endmodule

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] core_halt;
    logic       stpclk_req, sgack_resp, snp_act, snp_done;
    logic       irq_smi, irq_init, irq_bus, xhalt_en, xsg_en;
    logic [1:0] irq_lint;
    logic [3:0] pstate, irq_pend, irq_release;
    logic       sgack_req, core_clk_en, lowpt_req;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwr_state_ctrl #(.NCORE(2), .SG_DELAY(20)) dut (
        .clk (clk), .rst (rst), .core_halt (core_halt),
        .stpclk_req (stpclk_req), .sgack_resp (sgack_resp),
        .snp_act (snp_act), .snp_done (snp_done),
        .irq_smi (irq_smi), .irq_init (irq_init), .irq_lint (irq_lint),
        .irq_bus (irq_bus), .xhalt_en (xhalt_en), .xsg_en (xsg_en),
        .pstate (pstate), .sgack_req (sgack_req), .irq_pend (irq_pend),
        .irq_release (irq_release), .core_clk_en (core_clk_en),
        .lowpt_req (lowpt_req)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enter_sg_from_run(input logic ext);
        stpclk_req = 1'b1; xsg_en = ext;
        tick(1);
        sgack_resp = 1'b1;
        tick(1);
        sgack_resp = 1'b0; xsg_en = 1'b0;
        tick(20);
    endtask

    task automatic t_reset;
        rst = 1'b1; core_halt = '0; stpclk_req = 0; sgack_resp = 0;
        snp_act = 0; snp_done = 0; irq_smi = 0; irq_init = 0; irq_lint = '0;
        irq_bus = 0; xhalt_en = 0; xsg_en = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 state", pstate, 0);
        chk("R1 sgack_req", sgack_req, 0);
        chk("R1 irq_pend", irq_pend, 0);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 lowpt_req", lowpt_req, 0);
    endtask

    task automatic t_plain_halt;
        core_halt = 2'b01;
        tick(3);
        chk("R2 partial halt stays running", pstate, 0);
        core_halt = 2'b11;
        tick(1);
        chk("R2 plain halt", pstate, 1);
        chk("R11 clk gated in halt", core_clk_en, 0);
        chk("R11 lowpt off in halt", lowpt_req, 0);
        snp_act = 1'b1;
        tick(1);
        snp_act = 1'b0;
        chk("R10 halt snoop", pstate, 5);
        chk("R11 clk on in snoop", core_clk_en, 1);
        tick(2);
        chk("R10 snoop holds", pstate, 5);
        snp_done = 1'b1;
        tick(1);
        snp_done = 1'b0;
        chk("R10 back to halt", pstate, 1);
        irq_bus = 1'b1; core_halt = 2'b00;
        tick(1);
        irq_bus = 1'b0;
        chk("R3 bus irq wakes", pstate, 0);
        chk("R3 no release from halt", irq_release, 0);
    endtask

    task automatic t_ext_halt;
        xhalt_en = 1'b1; core_halt = 2'b11;
        tick(1);
        chk("R2 extended halt", pstate, 2);
        chk("R11 lowpt in xhalt", lowpt_req, 1);
        snp_act = 1'b1;
        tick(1);
        snp_act = 1'b0;
        chk("R10 xhalt snoop", pstate, 6);
        chk("R11 lowpt in xhalt snoop", lowpt_req, 1);
        snp_done = 1'b1;
        tick(1);
        snp_done = 1'b0;
        chk("R10 back to xhalt", pstate, 2);
        irq_smi = 1'b1; core_halt = 2'b00;
        tick(1);
        irq_smi = 1'b0; xhalt_en = 1'b0;
        chk("R3 smi wakes", pstate, 0);
    endtask

    task automatic t_halt_to_sg;
        xhalt_en = 1'b1; core_halt = 2'b11;
        tick(1);
        chk("R2 xhalt again", pstate, 2);
        xsg_en = 1'b0; stpclk_req = 1'b1;
        tick(1);
        chk("R4 halt to stop grant", pstate, 3);
        chk("R11 clk gated in sg", core_clk_en, 0);
        chk("R11 lowpt off in sg", lowpt_req, 0);
        irq_lint = 2'b10;
        tick(1);
        irq_lint = 2'b00;
        chk("R8 lint1 latched bit3", irq_pend, 4'b1000);
        stpclk_req = 1'b0;
        tick(1);
        chk("R4 returns to xhalt", pstate, 2);
        chk("R8 pend kept into halt", irq_pend, 4'b1000);
        tick(1);
        core_halt = 2'b00;
        chk("R12 pending wakes halt", pstate, 0);
        chk("R12 release vector", irq_release, 4'b1000);
        chk("R12 pend cleared", irq_pend, 0);
        xhalt_en = 1'b0;
        tick(1);
        chk("R8 release one cycle", irq_release, 0);
    endtask

    task automatic t_run_to_sg;
        stpclk_req = 1'b1;
        tick(1);
        chk("R5 ack requested", sgack_req, 1);
        tick(3);
        chk("R5 ack held", sgack_req, 1);
        chk("R5 still running", pstate, 0);
        sgack_resp = 1'b1;
        tick(1);
        sgack_resp = 1'b0;
        chk("R5 ack drops after response", sgack_req, 0);
        tick(19);
        chk("R5 not yet at 19", pstate, 0);
        tick(1);
        chk("R5 stop grant at 20", pstate, 3);
        snp_act = 1'b1;
        tick(1);
        snp_act = 1'b0;
        chk("R10 sg snoop", pstate, 7);
        snp_done = 1'b1; stpclk_req = 1'b0;
        tick(1);
        snp_done = 1'b0;
        chk("R10 back to sg first", pstate, 3);
        tick(1);
        chk("R10 then running", pstate, 0);
    endtask

    task automatic t_latch_exit;
        enter_sg_from_run(1'b0);
        chk("R5 sg via helper", pstate, 3);
        irq_smi = 1'b1;
        tick(1);
        irq_smi = 1'b0;
        tick(1);
        irq_smi = 1'b1;
        tick(1);
        irq_smi = 1'b0;
        chk("R8 repeated smi single bit", irq_pend, 4'b0001);
        chk("R8 latched not serviced", pstate, 3);
        stpclk_req = 1'b0; irq_lint = 2'b01;
        tick(1);
        irq_lint = 2'b00;
        chk("R8 exit to running", pstate, 0);
        chk("R8 release with same-cycle lint0", irq_release, 4'b0101);
        chk("R8 pend cleared on exit", irq_pend, 0);
    endtask

    task automatic t_abort_restart;
        stpclk_req = 1'b1;
        tick(1);
        sgack_resp = 1'b1;
        tick(1);
        sgack_resp = 1'b0;
        tick(5);
        stpclk_req = 1'b0;
        tick(1);
        chk("R6 abort stays running", pstate, 0);
        chk("R6 abort no ack", sgack_req, 0);
        tick(20);
        chk("R6 no late entry", pstate, 0);
        stpclk_req = 1'b1; xsg_en = 1'b1;
        tick(1);
        xsg_en = 1'b0;
        chk("R6 new ack cycle", sgack_req, 1);
        sgack_resp = 1'b1;
        tick(1);
        sgack_resp = 1'b0;
        tick(19);
        chk("R6 full count restarted", pstate, 0);
        tick(1);
        chk("R7 extended sg from arrival", pstate, 4);
        chk("R11 lowpt in xsg", lowpt_req, 1);
        stpclk_req = 1'b0;
        tick(1);
        chk("R7 xsg to running", pstate, 0);
    endtask

    task automatic t_reset_in_sg;
        core_halt = 2'b11;
        tick(1);
        chk("R2 halt for reset test", pstate, 1);
        xsg_en = 1'b1; stpclk_req = 1'b1;
        tick(1);
        xsg_en = 1'b0;
        chk("R4 halt to xsg", pstate, 4);
        irq_init = 1'b1;
        tick(1);
        irq_init = 1'b0;
        chk("R8 init bit1", irq_pend, 4'b0010);
        snp_act = 1'b1;
        tick(1);
        snp_act = 1'b0;
        chk("R10 xsg snoop", pstate, 8);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R9 reset keeps xsg", pstate, 4);
        chk("R9 reset clears pend", irq_pend, 0);
        stpclk_req = 1'b0;
        tick(1);
        core_halt = 2'b00;
        chk("R9 exit to running not halt", pstate, 0);
        tick(1);
        chk("R9 stays running", pstate, 0);
    endtask

    initial begin
        t_reset;
        t_plain_halt;
        t_ext_halt;
        t_halt_to_sg;
        t_run_to_sg;
        t_latch_exit;
        t_abort_restart;
        t_reset_in_sg;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule